// File: doc/BRIEF.md
# Segment Register Load Guard

This block judges whether a selector that is about to be written into a segment register under protected-mode rules may be loaded, and if it may not, which fault to raise and with which error code. The caller supplies the target register, the 16-bit selector, the current privilege level, the descriptor table limit and the already decoded attributes of the descriptor the selector points at, all qualified by a one-cycle request strobe. The block does not fetch descriptors. The answer appears on the registered outputs exactly one clock later.

The stack register and the four data registers follow different rules. A null selector (index bits all zero) is a fault for the stack register but a legal, silent load for the data registers. A missing segment raises a general protection fault for the stack register but a segment-not-present fault for a data register. Checks are ordered, and only the first failure is reported.

Internally a three-state machine holds the verdict: ST_IDLE (no answer this cycle), ST_ACCEPT (load granted) and ST_FAULT (fault reported). From any state, a request whose verdict passes moves to ST_ACCEPT and a failing one moves to ST_FAULT. A cycle without a request returns to ST_IDLE. Back-to-back requests move directly between ST_ACCEPT and ST_FAULT.

Top module: `seg_load_guard`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `load_grant` and `fault_valid` are low and `fault_code` is zero.
- R2: A request sampled with `req_valid` high at a rising edge produces exactly one of `load_grant` or `fault_valid` during the following cycle. A cycle without a request produces neither.
- R3: Target encoding is 0 for the stack register and 1 to 4 for the data registers (any nonzero code follows the data rules). A selector with bits 15:3 all zero, sent to the stack register, gives a general protection fault (`fault_kind` 0) with error code 0.
- R4: For the stack register, a general protection fault carrying the full selector as error code is raised if any of these hold: the descriptor lies beyond the table limit, the selector's RPL (bits 1:0) differs from CPL, the descriptor is not a writable data segment, or its DPL differs from CPL.
- R5: For the stack register, a descriptor that is not present gives a general protection fault (kind 0) with the selector as error code.
- R6: A null selector sent to a data register is granted with no fault, whatever the attributes.
- R7: The descriptor lies beyond the limit when {selector[15:3], 3'b111} is greater than `tbl_limit`. For a data register this gives a general protection fault with the selector as code. A selector whose last byte equals the limit passes this check.
- R8: For a data register, a code segment that is not readable gives a general protection fault with the selector as code.
- R9: For a data register whose segment is data or non-conforming code, RPL greater than DPL or CPL greater than DPL gives a general protection fault. A conforming readable code segment skips this check.
- R10: For a data register, a descriptor that is not present but passes all other checks gives a segment-not-present fault (`fault_kind` 1) with the selector as code.
- R11: Checks apply in the order null, limit, type and privilege, present. Only the first failing check is reported.
- R12: `load_grant` is high only when every check passes, and it is never high together with `fault_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request strobe, one cycle per selector |
| req_target | input | 3 | Target register: 0 stack, 1 to 4 data registers |
| req_sel | input | 16 | Selector being loaded |
| cur_cpl | input | 2 | Current privilege level |
| tbl_limit | input | 16 | Descriptor table limit in bytes |
| dsc_present | input | 1 | Descriptor present bit |
| dsc_is_code | input | 1 | 1 for a code segment, 0 for a data segment |
| dsc_writable | input | 1 | Data segment is writable |
| dsc_readable | input | 1 | Code segment is readable |
| dsc_conforming | input | 1 | Code segment is conforming |
| dsc_dpl | input | 2 | Descriptor privilege level |
| load_grant | output | 1 | Load may proceed |
| fault_valid | output | 1 | Load is refused |
| fault_kind | output | 1 | 0 general protection, 1 segment not present |
| fault_code | output | 16 | Error code accompanying the fault |

## Verification
A corrupted verdict state appears one cycle after the request as a grant where a fault belongs, or the reverse, or as both or neither strobe. A stale captured code or kind appears as a wrong `fault_code` or `fault_kind` in that same cycle. Because each answer lands in a fixed cycle, a scoreboard can compare every response against a value derived from the rules with no search window. Priority errors are exposed by descriptors that break two rules at once, where the reported fault kind or code tells which check fired first.

// File: rtl/seg_guard_pkg.sv
package seg_guard_pkg;

    typedef enum logic [2:0] {
        TGT_SS = 3'd0,
        TGT_DS = 3'd1,
        TGT_ES = 3'd2,
        TGT_FS = 3'd3,
        TGT_GS = 3'd4
    } seg_tgt_e;

    typedef enum logic {
        FLT_GP = 1'b0,
        FLT_NP = 1'b1
    } flt_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCEPT = 2'd1,
        ST_FAULT  = 2'd2
    } guard_st_e;

    typedef struct packed {
        logic       present;
        logic       is_code;
        logic       writable;
        logic       readable;
        logic       conforming;
        logic [1:0] dpl;
    } seg_attr_t;

    typedef struct packed {
        logic      fail;
        flt_kind_e kind;
        logic      zero_code;
    } verdict_t;

endpackage

// File: rtl/seg_limit_cmp.sv
module seg_limit_cmp #(
    parameter int SEL_W = 16,
    parameter int LIM_W = 16
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [LIM_W-1:0] limit,
    output logic             over
);
    localparam int CMP_W = (SEL_W > LIM_W) ? SEL_W : LIM_W;

    logic [SEL_W-1:0] last_byte;
    logic [CMP_W-1:0] last_ext;
    logic [CMP_W-1:0] lim_ext;

    always_comb begin
        last_byte = {sel[SEL_W-1:3], 3'b111};
        last_ext  = CMP_W'(last_byte);
        lim_ext   = CMP_W'(limit);
        over      = last_ext > lim_ext;
    end
endmodule

// File: rtl/seg_rule_eval.sv
module seg_rule_eval
    import seg_guard_pkg::*;
#(
    parameter int SEL_W = 16
) (
    input  logic             is_stack,
    input  logic [SEL_W-1:0] sel,
    input  logic [1:0]       cpl,
    input  seg_attr_t        attr,
    input  logic             over_limit,
    output verdict_t         verdict
);
    logic       is_null;
    logic [1:0] rpl;
    logic       stk_bad;
    logic       typ_bad;
    logic       prv_bad;

    always_comb begin
        is_null = (sel[SEL_W-1:3] == '0);
        rpl     = sel[1:0];
        stk_bad = (rpl != cpl) || attr.is_code || !attr.writable || (attr.dpl != cpl);
        typ_bad = attr.is_code && !attr.readable;
        prv_bad = (!attr.is_code || !attr.conforming) &&
                  ((rpl > attr.dpl) || (cpl > attr.dpl));

        verdict = '{fail: 1'b0, kind: FLT_GP, zero_code: 1'b0};
        if (is_stack) begin
            if (is_null) begin
                verdict = '{fail: 1'b1, kind: FLT_GP, zero_code: 1'b1};
            end else if (over_limit || stk_bad || !attr.present) begin
                verdict = '{fail: 1'b1, kind: FLT_GP, zero_code: 1'b0};
            end
        end else begin
            if (is_null) begin
                verdict = '{fail: 1'b0, kind: FLT_GP, zero_code: 1'b0};
            end else if (over_limit || typ_bad || prv_bad) begin
                verdict = '{fail: 1'b1, kind: FLT_GP, zero_code: 1'b0};
            end else if (!attr.present) begin
                verdict = '{fail: 1'b1, kind: FLT_NP, zero_code: 1'b0};
            end
        end
    end
endmodule

// File: rtl/seg_load_guard.sv
module seg_load_guard
    import seg_guard_pkg::*;
#(
    parameter int SEL_W = 16,
    parameter int LIM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [2:0]       req_target,
    input  logic [SEL_W-1:0] req_sel,
    input  logic [1:0]       cur_cpl,
    input  logic [LIM_W-1:0] tbl_limit,
    input  logic             dsc_present,
    input  logic             dsc_is_code,
    input  logic             dsc_writable,
    input  logic             dsc_readable,
    input  logic             dsc_conforming,
    input  logic [1:0]       dsc_dpl,
    output logic             load_grant,
    output logic             fault_valid,
    output logic             fault_kind,
    output logic [SEL_W-1:0] fault_code
);
    guard_st_e        state_q, state_d;
    flt_kind_e        kind_q;
    logic [SEL_W-1:0] code_q;
    seg_attr_t        attr;
    verdict_t         verdict;
    logic             over_limit;
    logic             is_stack;

    always_comb begin
        attr     = '{present: dsc_present, is_code: dsc_is_code,
                     writable: dsc_writable, readable: dsc_readable,
                     conforming: dsc_conforming, dpl: dsc_dpl};
        is_stack = (seg_tgt_e'(req_target) == TGT_SS);
    end

    seg_limit_cmp #(.SEL_W(SEL_W), .LIM_W(LIM_W)) u_limit (
        .sel   (req_sel),
        .limit (tbl_limit),
        .over  (over_limit)
    );

    seg_rule_eval #(.SEL_W(SEL_W)) u_rules (
        .is_stack   (is_stack),
        .sel        (req_sel),
        .cpl        (cur_cpl),
        .attr       (attr),
        .over_limit (over_limit),
        .verdict    (verdict)
    );

    // next-state: every state reacts to a new request the same way
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_ACCEPT, ST_FAULT: begin
                if (req_valid) begin
                    state_d = verdict.fail ? ST_FAULT : ST_ACCEPT;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and captured fault details
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= FLT_GP;
            code_q  <= '0;
        end else begin
            state_q <= state_d;
            if (req_valid) begin
                kind_q <= verdict.kind;
                code_q <= verdict.zero_code ? '0 : req_sel;
            end
        end
    end

    // outputs decoded from the state
    always_comb begin
        load_grant  = 1'b0;
        fault_valid = 1'b0;
        fault_kind  = FLT_GP;
        fault_code  = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ACCEPT: load_grant = 1'b1;
            ST_FAULT: begin
                fault_valid = 1'b1;
                fault_kind  = kind_q;
                fault_code  = code_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/seg_load_guard_chk.sv
module seg_load_guard_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [2:0]  req_target,
    input logic [15:0] req_sel,
    input logic        load_grant,
    input logic        fault_valid,
    input logic        fault_kind,
    input logic [15:0] fault_code
);
    AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (load_grant ^ fault_valid));                        // R2

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (load_grant || fault_valid) |-> $past(req_valid));                  // R2

    AST_GRANT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_grant && fault_valid));                                      // R12

    AST_STACK_NULL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_target == 3'd0 && req_sel[15:3] == 13'd0)
        |=> (fault_valid && !fault_kind && fault_code == 16'd0));           // R3

    AST_DATA_NULL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_target != 3'd0 && req_sel[15:3] == 13'd0)
        |=> load_grant);                                                    // R6

    AST_NP_DATA_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && fault_kind) |-> ($past(req_target) != 3'd0));      // R5

    AST_NP_CODE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && fault_kind) |-> (fault_code == $past(req_sel)));    // R10
endmodule

bind seg_load_guard seg_load_guard_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_target  (req_target),
    .req_sel     (req_sel),
    .load_grant  (load_grant),
    .fault_valid (fault_valid),
    .fault_kind  (fault_kind),
    .fault_code  (fault_code)
);

// File: tb/seg_load_guard_test.sv
`timescale 1ns/1ps
module seg_load_guard_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_target = '0;
    logic [15:0] req_sel = '0;
    logic [1:0]  cur_cpl = '0;
    logic [15:0] tbl_limit = 16'h00FF;
    logic        dsc_present = 1'b0, dsc_is_code = 1'b0, dsc_writable = 1'b0;
    logic        dsc_readable = 1'b0, dsc_conforming = 1'b0;
    logic [1:0]  dsc_dpl = '0;
    logic        load_grant, fault_valid, fault_kind;
    logic [15:0] fault_code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic        grant;
        logic        kind;
        logic [15:0] code;
        string       req;
    } exp_t;
    exp_t exp_q[$];
    logic due = 1'b0;

    always #4 clk = ~clk;

    seg_load_guard uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_target(req_target),
        .req_sel(req_sel), .cur_cpl(cur_cpl), .tbl_limit(tbl_limit),
        .dsc_present(dsc_present), .dsc_is_code(dsc_is_code),
        .dsc_writable(dsc_writable), .dsc_readable(dsc_readable),
        .dsc_conforming(dsc_conforming), .dsc_dpl(dsc_dpl),
        .load_grant(load_grant), .fault_valid(fault_valid),
        .fault_kind(fault_kind), .fault_code(fault_code)
    );

    always @(posedge clk) due <= req_valid;

    function automatic logic [15:0] mksel(input int idx, input int rpl);
        return 16'((idx << 3) | (rpl & 3));
    endfunction

    // driver: apply one request and push the expected answer
    task automatic send(input logic [2:0] tgt, input logic [15:0] sel, input logic [1:0] cpl,
                        input logic p, input logic c, input logic w, input logic r,
                        input logic cf, input logic [1:0] dpl,
                        input logic eg, input logic ek, input logic [15:0] ec, input string req);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_target = tgt; req_sel = sel; cur_cpl = cpl;
        dsc_present = p; dsc_is_code = c; dsc_writable = w; dsc_readable = r;
        dsc_conforming = cf; dsc_dpl = dpl;
        e.grant = eg; e.kind = ek; e.code = ec; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // monitor: compare in the cycle after each request
    always @(negedge clk) begin
        if (rst_n && due) begin
            exp_t e;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R2 unexpected answer with empty scoreboard");
            end else begin
                e = exp_q.pop_front();
                if (e.grant) begin
                    if (load_grant !== 1'b1 || fault_valid !== 1'b0) begin
                        errors++;
                        $display("FAIL %s grant=%b fault=%b expected grant=1 fault=0",
                                 e.req, load_grant, fault_valid);
                    end
                end else if (load_grant !== 1'b0 || fault_valid !== 1'b1 ||
                             fault_kind !== e.kind || fault_code !== e.code) begin
                    errors++;
                    $display("FAIL %s grant=%b fault=%b kind=%b code=%h expected grant=0 fault=1 kind=%b code=%h",
                             e.req, load_grant, fault_valid, fault_kind, fault_code, e.kind, e.code);
                end
            end
        end else if (rst_n && !due) begin
            if (load_grant !== 1'b0 || fault_valid !== 1'b0) begin
                checks++;
                errors++;
                $display("FAIL R2 answer without request grant=%b fault=%b expected 0 0",
                         load_grant, fault_valid);
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (load_grant !== 1'b0 || fault_valid !== 1'b0 || fault_code !== 16'h0) begin
            errors++;
            $display("FAIL R1 grant=%b fault=%b code=%h expected 0 0 0000",
                     load_grant, fault_valid, fault_code);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (load_grant !== 1'b0 || fault_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 after release grant=%b fault=%b expected 0 0", load_grant, fault_valid);
        end

        // stack register
        send(3'd0, 16'h0003, 2'd0, 1,0,1,0,0, 2'd0, 0,0,16'h0000, "R3 stack null");
        send(3'd0, mksel(5,0), 2'd0, 1,0,1,0,0, 2'd0, 1,0,16'h0, "R12 stack good");
        send(3'd0, mksel(40,0), 2'd0, 1,0,1,0,0, 2'd0, 0,0,mksel(40,0), "R4 stack limit");
        send(3'd0, mksel(5,1), 2'd0, 1,0,1,0,0, 2'd0, 0,0,mksel(5,1), "R4 stack rpl");
        send(3'd0, mksel(6,0), 2'd0, 1,0,0,0,0, 2'd0, 0,0,mksel(6,0), "R4 stack readonly");
        send(3'd0, mksel(7,0), 2'd0, 1,1,1,1,0, 2'd0, 0,0,mksel(7,0), "R4 stack code");
        send(3'd0, mksel(8,0), 2'd0, 1,0,1,0,0, 2'd1, 0,0,mksel(8,0), "R4 stack dpl");
        send(3'd0, mksel(9,2), 2'd2, 0,0,1,0,0, 2'd2, 0,0,mksel(9,2), "R5 stack absent");
        send(3'd0, 16'h0000, 2'd0, 0,0,0,0,0, 2'd0, 0,0,16'h0000, "R11 stack null absent");
        idle_cycle();
        idle_cycle();

        // data registers
        send(3'd1, 16'h0002, 2'd3, 0,1,0,0,0, 2'd0, 1,0,16'h0, "R6 data null");
        send(3'd2, mksel(32,0), 2'd0, 1,0,1,0,0, 2'd0, 0,0,mksel(32,0), "R7 data limit");
        send(3'd2, mksel(31,0), 2'd0, 1,0,0,0,0, 2'd0, 1,0,16'h0, "R7 data limit edge");
        send(3'd3, mksel(3,0), 2'd0, 1,1,0,0,0, 2'd0, 0,0,mksel(3,0), "R8 code unreadable");
        send(3'd4, mksel(4,3), 2'd3, 1,1,0,1,0, 2'd3, 1,0,16'h0, "R8 code readable");
        send(3'd1, mksel(10,0), 2'd3, 1,0,1,0,0, 2'd0, 0,0,mksel(10,0), "R9 cpl above dpl");
        send(3'd1, mksel(11,3), 2'd0, 1,0,1,0,0, 2'd2, 0,0,mksel(11,3), "R9 rpl above dpl");
        send(3'd2, mksel(12,3), 2'd3, 1,1,0,1,1, 2'd0, 1,0,16'h0, "R9 conforming skip");
        send(3'd1, mksel(13,0), 2'd0, 0,0,1,0,0, 2'd0, 0,1,mksel(13,0), "R10 data absent");
        send(3'd4, mksel(50,1), 2'd0, 0,0,1,0,0, 2'd3, 0,0,mksel(50,1), "R11 limit before absent");
        send(3'd3, mksel(14,3), 2'd0, 0,0,1,0,0, 2'd1, 0,0,mksel(14,3), "R11 priv before absent");
        idle_cycle();
        idle_cycle();
        idle_cycle();

        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R2 %0d answers missing, expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule